// File: doc/BRIEF.md
# Bus Trace Trigger and Capture Window Generator

This block sits beside an on-chip bus and decides when a trace recorder downstream should store samples. Software loads a small set of event comparators, a capture depth and a control word through a write-only register port, then arms the block. Every cycle the block compares the observed bus transfer against each enabled comparator. It also watches a single external event pin, which can stand in for a comparator hit. The first qualifying event while armed is the trigger.

Two capture windows are offered. In post-trigger form, nothing is captured while armed; capture starts the cycle after the trigger and lasts for the programmed depth. In pre-trigger form, capture runs for the whole armed period, so the downstream store keeps a rolling history; after the trigger it continues for the programmed depth and then freezes. Either way, a one-cycle done pulse marks the end of capture, and the block then ignores all events until software arms it again. A mode code from the control word is passed through to the later stages and may be changed at any time, even mid-trace.

The bus observation input is a one-way sample stream qualified only by `bus_valid`. The block has no ready output, because a monitor may never stall the bus it watches: it accepts every valid sample in the cycle it arrives. The capture outputs are plain level signals, and the downstream stage must take a sample in every cycle that `cap_en` is high.

Top module: `trace_trig_gen`

## Requirements
- R1: After reset, `cap_en`, `cap_done` and `depth_left` are 0 and `cap_mode` is 0.
- R2: A comparator hits on a valid transfer when every address bit whose mask bit is 0 equals the stored value bit. Mask bits set to 1 are don't-care.
- R3: Comparator config word bit 1 permits hits on reads (`bus_write`=0) and bit 2 permits hits on writes (`bus_write`=1). A transfer of a direction that is not permitted never hits.
- R4: A comparator whose config bit 0 (enable) is 0 never hits, and no comparator hits while `bus_valid` is 0.
- R5: `ext_event` triggers only when control bit 2 (external enable) is 1. Otherwise it is ignored.
- R6: Post-trigger (control bit 1 = 0 at arming): `cap_en` is low while armed. It rises in the cycle after the trigger and stays high for exactly depth cycles, while `depth_left` counts depth, depth-1, ..., 1.
- R7: Pre-trigger (control bit 1 = 1 at arming): `cap_en` is high from the cycle after the arming write for as long as the block is armed, and then stays high for depth cycles after the trigger.
- R8: `cap_done` is high for exactly one cycle, the first cycle in which `cap_en` is low after a capture. With depth 0, `cap_done` pulses the cycle after the trigger and no post-trigger cycles are captured.
- R9: Arming is a write to control address 0 with bit 0 = 1, and it takes effect only when the block is idle. Events arriving while idle or capturing are ignored, and so are arming writes made while armed or capturing.
- R10: `cap_mode` equals control bits 5:3 of the most recent control write, from the cycle after that write.
- R11: Register addresses: 0 control, 1 depth, and for comparator i: 2+3i value, 3+3i mask, 4+3i config. The depth is sampled when the trigger occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Observed transfer is valid this cycle |
| bus_addr | input | 32 | Observed transfer address |
| bus_write | input | 1 | Observed transfer direction, 1 = write |
| ext_event | input | 1 | External trigger event |
| cap_en | output | 1 | Capture enable for downstream stages |
| cap_mode | output | 3 | Trace mode code for downstream stages |
| depth_left | output | 16 | Remaining post-trigger capture cycles |
| cap_done | output | 1 | One-cycle end-of-capture pulse |

## Verification
The checker enforces, on every cycle, the shape of the capture window: the remaining-depth count falls by one per cycle, the count is nonzero only while capture is enabled, the done pulse lasts one cycle, it follows the last counted cycle with capture low, and the mode output tracks control writes. Which transfers hit which comparator — mask, direction, enable and the external-enable gate — and the distinction between the pre-trigger and post-trigger windows can only be shown by the bench's scenarios. The same holds for ignoring events and arming writes outside the armed state, and for the depth-zero corner.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int MODE_W   = 3;
  localparam int ARM_BIT  = 0;
  localparam int PRE_BIT  = 1;
  localparam int EXT_BIT  = 2;
  localparam int MODE_LSB = 3;
  localparam int EV_EN_BIT = 0;
  localparam int EV_RD_BIT = 1;
  localparam int EV_WR_BIT = 2;
  localparam int REG_CTRL  = 0;
  localparam int REG_DEPTH = 1;
  localparam int REG_EV0   = 2;
  localparam int REGS_PER_EV = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_TAIL  = 2'd3
  } win_state_e;

  typedef struct packed {
    logic              ext_en;
    logic [MODE_W-1:0] mode;
  } trig_ctrl_t;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 16,
  parameter int CFG_AW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  output trig_ctrl_t          ctrl,
  output logic                arm_req,
  output logic                arm_pre,
  output logic [DEPTH_W-1:0]  depth_val,
  output logic [ADDR_W-1:0]   ev_val  [NUM_EVT],
  output logic [ADDR_W-1:0]   ev_mask [NUM_EVT],
  output logic [NUM_EVT-1:0]  ev_en,
  output logic [NUM_EVT-1:0]  ev_rd,
  output logic [NUM_EVT-1:0]  ev_wr
);
  logic ctrl_sel, depth_sel;

  assign ctrl_sel  = cfg_we && (cfg_addr == CFG_AW'(REG_CTRL));
  assign depth_sel = cfg_we && (cfg_addr == CFG_AW'(REG_DEPTH));
  assign arm_req   = ctrl_sel && cfg_wdata[ARM_BIT];
  assign arm_pre   = cfg_wdata[PRE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      depth_val <= '0;
    end else begin
      if (ctrl_sel) begin
        ctrl.ext_en <= cfg_wdata[EXT_BIT];
        ctrl.mode   <= cfg_wdata[MODE_LSB +: MODE_W];
      end
      if (depth_sel) depth_val <= cfg_wdata[DEPTH_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_ev
    localparam int VAL_A  = REG_EV0 + REGS_PER_EV * i;
    localparam int MASK_A = VAL_A + 1;
    localparam int CFG_A  = VAL_A + 2;
    logic sel_val, sel_mask, sel_cfg;
    assign sel_val  = cfg_we && (cfg_addr == CFG_AW'(VAL_A));
    assign sel_mask = cfg_we && (cfg_addr == CFG_AW'(MASK_A));
    assign sel_cfg  = cfg_we && (cfg_addr == CFG_AW'(CFG_A));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_val[i]  <= '0;
        ev_mask[i] <= '0;
        ev_en[i]   <= 1'b0;
        ev_rd[i]   <= 1'b0;
        ev_wr[i]   <= 1'b0;
      end else begin
        if (sel_val)  ev_val[i]  <= cfg_wdata;
        if (sel_mask) ev_mask[i] <= cfg_wdata;
        if (sel_cfg) begin
          ev_en[i] <= cfg_wdata[EV_EN_BIT];
          ev_rd[i] <= cfg_wdata[EV_RD_BIT];
          ev_wr[i] <= cfg_wdata[EV_WR_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/trig_evt_match.sv
module trig_evt_match #(
  parameter int ADDR_W = 32
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] ref_val,
  input  logic [ADDR_W-1:0] ref_mask,
  input  logic              ref_en,
  input  logic              ref_rd,
  input  logic              ref_wr,
  output logic              hit
);
  logic addr_ok, dir_ok;

  // mask bit 1 = don't care
  assign addr_ok = ~|((bus_addr ^ ref_val) & ~ref_mask);
  assign dir_ok  = bus_write ? ref_wr : ref_rd;
  assign hit     = bus_valid && ref_en && addr_ok && dir_ok;
endmodule

// File: rtl/trig_window_fsm.sv
module trig_window_fsm
  import trig_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_req,
  input  logic               arm_pre,
  input  logic               trigger,
  input  logic [DEPTH_W-1:0] depth_val,
  output logic               cap_en,
  output logic [DEPTH_W-1:0] depth_left,
  output logic               cap_done
);
  win_state_e         state;
  logic               pre_q;
  logic [DEPTH_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pre_q    <= 1'b0;
      cnt      <= '0;
      cap_done <= 1'b0;
    end else begin
      cap_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (arm_req) begin
            state <= ST_ARMED;
            pre_q <= arm_pre;
          end
        end
        ST_ARMED: begin
          if (trigger) begin
            if (depth_val == '0) begin
              state    <= ST_IDLE;
              cap_done <= 1'b1;
            end else begin
              cnt   <= depth_val;
              state <= pre_q ? ST_TAIL : ST_POST;
            end
          end
        end
        ST_POST, ST_TAIL: begin
          if (cnt == DEPTH_W'(1)) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cap_done <= 1'b1;
          end else begin
            cnt <= cnt - DEPTH_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cap_en = (state == ST_POST) || (state == ST_TAIL) ||
                  ((state == ST_ARMED) && pre_q);
  assign depth_left = cnt;
endmodule

// File: rtl/trace_trig_gen.sv
module trace_trig_gen
  import trig_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 16,
  parameter int CFG_AW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_write,
  input  logic               ext_event,
  output logic               cap_en,
  output logic [MODE_W-1:0]  cap_mode,
  output logic [DEPTH_W-1:0] depth_left,
  output logic               cap_done
);
  trig_ctrl_t         ctrl;
  logic               arm_req, arm_pre, trigger;
  logic [DEPTH_W-1:0] depth_val;
  logic [ADDR_W-1:0]  ev_val  [NUM_EVT];
  logic [ADDR_W-1:0]  ev_mask [NUM_EVT];
  logic [NUM_EVT-1:0] ev_en, ev_rd, ev_wr, ev_hit;

  trig_cfg_regs #(
    .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl), .arm_req(arm_req), .arm_pre(arm_pre),
    .depth_val(depth_val), .ev_val(ev_val), .ev_mask(ev_mask),
    .ev_en(ev_en), .ev_rd(ev_rd), .ev_wr(ev_wr)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
    trig_evt_match #(.ADDR_W(ADDR_W)) u_match (
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
      .ref_val(ev_val[i]), .ref_mask(ev_mask[i]), .ref_en(ev_en[i]),
      .ref_rd(ev_rd[i]), .ref_wr(ev_wr[i]), .hit(ev_hit[i])
    );
  end

  assign trigger  = (|ev_hit) || (ctrl.ext_en && ext_event);
  assign cap_mode = ctrl.mode;

  trig_window_fsm #(.DEPTH_W(DEPTH_W)) u_win (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .arm_pre(arm_pre),
    .trigger(trigger), .depth_val(depth_val), .cap_en(cap_en),
    .depth_left(depth_left), .cap_done(cap_done)
  );
endmodule

// File: rtl/trace_trig_gen_chk.sv
module trace_trig_gen_chk
  import trig_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 16,
  parameter int CFG_AW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [CFG_AW-1:0]  cfg_addr,
  input logic [ADDR_W-1:0]  cfg_wdata,
  input logic               cap_en,
  input logic [MODE_W-1:0]  cap_mode,
  input logic [DEPTH_W-1:0] depth_left,
  input logic               cap_done
);
  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_left > DEPTH_W'(1)) |=> (depth_left == $past(depth_left) - DEPTH_W'(1)));

  // R6
  count_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_left != '0) |-> cap_en);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_left == DEPTH_W'(1)) |=> (cap_done && !cap_en));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> !cap_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> (!cap_en && depth_left == '0));

  // R10
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(REG_CTRL)) |=>
      (cap_mode == $past(cfg_wdata[MODE_LSB +: MODE_W])));
endmodule

bind trace_trig_gen trace_trig_gen_chk #(
  .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cap_en(cap_en), .cap_mode(cap_mode),
  .depth_left(depth_left), .cap_done(cap_done)
);

// File: tb/trace_trig_gen_bench.sv
module trace_trig_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        ext_event = 1'b0;
  logic        cap_en;
  logic [2:0]  cap_mode;
  logic [15:0] depth_left;
  logic        cap_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    chk;
    bit    cap;
    int    dep;
    bit    done;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  trace_trig_gen u_trace_trig_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .ext_event(ext_event), .cap_en(cap_en),
    .cap_mode(cap_mode), .depth_left(depth_left), .cap_done(cap_done)
  );

  localparam logic [31:0] E0V = 32'h1000_0040;
  localparam logic [31:0] E0M = 32'h0000_000F;
  localparam logic [31:0] E1V = 32'h2000_0000;

  // monitor: compare each expected item just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        if (it.chk) begin
          checks++;
          if (cap_en !== it.cap || int'(depth_left) != it.dep || cap_done !== it.done) begin
            failures++;
            $display("FAIL %s: cap_en=%0b depth_left=%0d cap_done=%0b expected %0b %0d %0b",
                     it.tag, cap_en, depth_left, cap_done, it.cap, it.dep, it.done);
          end
        end
      end
    end
  end

  task automatic push(bit chk, bit cap, int dep, bit done, string tag);
    exp_t it;
    it.chk = chk; it.cap = cap; it.dep = dep; it.done = done; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drv(bit bv, logic [31:0] a, bit wr, bit ext,
                     bit cap, int dep, bit done, string tag);
    cfg_we = 1'b0;
    bus_valid = bv; bus_addr = a; bus_write = wr; ext_event = ext;
    push(1'b1, cap, dep, done, tag);
    @(negedge clk);
  endtask

  task automatic idle(bit cap, int dep, bit done, string tag);
    drv(1'b0, '0, 1'b0, 1'b0, cap, dep, done, tag);
  endtask

  task automatic wr_cfg(int a, logic [31:0] d, bit chk, bit cap, int dep, bit done, string tag);
    bus_valid = 1'b0; ext_event = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    push(chk, cap, dep, done, tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_mode(int m, string tag);
    checks++;
    if (int'(cap_mode) != m) begin
      failures++;
      $display("FAIL %s: cap_mode=%0d expected %0d", tag, cap_mode, m);
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (cap_en !== 1'b0 || cap_done !== 1'b0 || depth_left !== '0 || cap_mode !== '0) begin
      failures++;
      $display("FAIL R1: cap_en=%0b done=%0b depth=%0d mode=%0d expected 0 0 0 0",
               cap_en, cap_done, depth_left, cap_mode);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(0, 0, 0, "R1 idle after reset");

    // R11 register layout: comparator 0 at 2..4, comparator 1 at 5..7
    wr_cfg(2, E0V, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(3, E0M, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(4, 32'h3, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(5, E1V, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(6, 32'h0, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(7, 32'h5, 1, 0, 0, 0, "R11 cfg");
    wr_cfg(1, 32'd3, 1, 0, 0, 0, "R11 cfg");

    // post-trigger, mode 2
    wr_cfg(0, 32'h11, 1, 0, 0, 0, "R6 arm post");
    chk_mode(2, "R10 mode after write");
    drv(1, 32'h1000_0050, 0, 0, 0, 0, 0, "R2 unmasked bit differs");
    drv(1, 32'h1000_004A, 1, 0, 0, 0, 0, "R3 write not permitted");
    drv(1, 32'h2000_0000, 0, 0, 0, 0, 0, "R3 read not permitted");
    drv(1, 32'h1000_004A, 0, 0, 1, 3, 0, "R2 masked hit starts capture");
    drv(1, 32'h2000_0000, 1, 0, 1, 2, 0, "R6 count");
    idle(1, 1, 0, "R6 count");
    idle(0, 0, 1, "R8 done pulse");
    idle(0, 0, 0, "R8 done single");

    // R9 events ignored after done
    drv(1, 32'h1000_0041, 0, 0, 0, 0, 0, "R9 no capture when idle");
    drv(1, 32'h2000_0000, 1, 0, 0, 0, 0, "R9 no capture when idle");
    idle(0, 0, 0, "R9 still idle");

    // external event gating, disabled comparator
    wr_cfg(0, 32'h01, 1, 0, 0, 0, "R5 arm ext off");
    drv(0, '0, 0, 1, 0, 0, 0, "R5 ext ignored");
    wr_cfg(4, 32'h2, 1, 0, 0, 0, "R4 disable cmp0");
    drv(1, 32'h1000_0040, 0, 0, 0, 0, 0, "R4 disabled comparator");
    drv(0, 32'h2000_0000, 1, 0, 0, 0, 0, "R4 invalid transfer");
    wr_cfg(0, 32'h1C, 1, 0, 0, 0, "R5 ext on, no arm");
    chk_mode(3, "R10 mode changed while armed");
    drv(0, '0, 0, 1, 1, 3, 0, "R5 ext triggers");
    idle(1, 2, 0, "R6 count");
    idle(1, 1, 0, "R6 count");
    idle(0, 0, 1, "R8 done");
    idle(0, 0, 0, "R8 done single");
    wr_cfg(4, 32'h3, 1, 0, 0, 0, "R4 re-enable");

    // pre-trigger, depth 2
    wr_cfg(1, 32'd2, 1, 0, 0, 0, "R11 depth");
    wr_cfg(0, 32'h03, 1, 1, 0, 0, "R7 arm pre, capture on");
    idle(1, 0, 0, "R7 capture while armed");
    drv(1, 32'h2000_0000, 0, 0, 1, 0, 0, "R7 read not a hit");
    drv(1, 32'h2000_0000, 1, 0, 1, 2, 0, "R7 trigger tail");
    idle(1, 1, 0, "R7 tail");
    idle(0, 0, 1, "R8 done pre");
    idle(0, 0, 0, "R8 done single pre");

    // depth 0
    wr_cfg(1, 32'd0, 1, 0, 0, 0, "R11 depth");
    wr_cfg(0, 32'h01, 1, 0, 0, 0, "R8 arm post d0");
    drv(1, 32'h2000_0000, 1, 0, 0, 0, 1, "R8 depth0 post done");
    idle(0, 0, 0, "R8 depth0 post");
    wr_cfg(0, 32'h03, 1, 1, 0, 0, "R8 arm pre d0");
    drv(1, 32'h2000_0000, 1, 0, 0, 0, 1, "R8 depth0 pre done");
    idle(0, 0, 0, "R8 depth0 pre");

    // R9 arming while capturing ignored
    wr_cfg(1, 32'd4, 1, 0, 0, 0, "R11 depth");
    wr_cfg(0, 32'h01, 1, 0, 0, 0, "R9 arm post");
    drv(1, 32'h2000_0000, 1, 0, 1, 4, 0, "R9 trigger");
    wr_cfg(0, 32'h03, 1, 1, 3, 0, "R9 arm during capture");
    idle(1, 2, 0, "R9 count");
    idle(1, 1, 0, "R9 count");
    idle(0, 0, 1, "R9 done");
    idle(0, 0, 0, "R9 no new pre capture");
    idle(0, 0, 0, "R9 no new pre capture");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule